// File: doc/BRIEF.md
# Oscillator-Sampled Entropy Collector

This block turns a bank of free-running oscillator outputs into 32-bit entropy words. At a fixed interval of clock cycles it takes a snapshot of the whole oscillator vector and folds it to one bit by XOR. Two such folded snapshots, one interval apart, are XORed to give one entropy bit. Each entropy bit is shifted into a 32-bit register. Collection never pauses: once the register is full, every new bit pushes the oldest one out.

A consumer reads the block through a small read port with two addresses. One address returns a status word that carries a ready flag. The other returns the entropy word. The ready flag means that a whole word of fresh bits has arrived since the last read of the data address. Reading the data address withdraws the flag. The flag comes back only after another full word of fresh bits has been collected. The sample interval and the oscillator count are parameters, so a bench can use a short interval.

Top module: `osc_entropy_collector`

## Requirements
- R1: A synchronous active-high reset clears the entropy word, the fresh-bit count, the sample phase and the interval counter. During reset and on the first cycle after it, `word_o` is 0 and `ready_o` is 0.
- R2: The oscillator vector is sampled on the clock edge that ends every INTERVAL cycles after reset. The first sample is taken on edge INTERVAL and the second on edge 2*INTERVAL. An entropy bit is produced only on every second sample, and `word_o` does not change on any other edge.
- R3: An entropy bit equals the XOR of all oscillator bits at the first sample, XORed with the XOR of all oscillator bits at the second sample. The bit enters at bit 0 of `word_o`, and the other bits move up by one position.
- R4: Bits keep shifting in whether or not the word has been read, and the bit in position WORD_W-1 is discarded.
- R5: `ready_o` rises on the edge that brings in the WORD_W-th fresh bit since reset or since the last data read.
- R6: A data read (`rd_en`=1 with `rd_addr`=1) on an edge that brings in no new bit clears `ready_o`. `ready_o` stays 0 until WORD_W new bits have arrived.
- R7: If a data read falls on the same edge as a new bit, that bit counts as fresh. `ready_o` then rises after WORD_W-1 further bits.
- R8: `rd_data` is combinational. With `rd_addr`=0 it shows the status word: bit 0 is the ready flag and all other bits are 0. With `rd_addr`=1 it shows `word_o`.
- R9: Reading the status address does not change `ready_o`.
- R10: The fresh-bit count saturates. Without a data read, `ready_o` stays 1 however many more bits arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_i | input | NUM_OSC | Oscillator output bits |
| rd_en | input | 1 | Read strobe for the read port |
| rd_addr | input | 1 | 0 selects status, 1 selects the entropy word |
| rd_data | output | WORD_W | Read data for the selected address |
| word_o | output | WORD_W | Current entropy word |
| ready_o | output | 1 | Fresh-word ready flag |

## Verification
Two functions can fall on the same edge: the clearing of the fresh-bit count by a data read, and the arrival of a new entropy bit. The bench uses its reference model to find the negative edge just before a second-sample edge, and issues a one-cycle data read there. It then counts bits and expects `ready_o` to rise after WORD_W-1 further bits, not WORD_W. A separate data read placed on a quiet edge checks the opposite case: there the flag must still be low after WORD_W-1 bits and high after WORD_W.

// File: rtl/ent_pkg.sv
package ent_pkg;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        logic vld;
        logic val;
    } ent_bit_t;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_DATA   = 1'b1;

endpackage

// File: rtl/ent_sampler.sv
module ent_sampler
    import ent_pkg::*;
#(
    parameter int NUM_OSC  = 32,
    parameter int INTERVAL = 4096
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OSC-1:0] osc_i,
    output ent_bit_t           bit_o
);

    localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] cnt_q;
    phase_e           phase_q;
    logic             first_q;
    logic             tick;
    logic             fold;

    assign tick = (cnt_q == LAST);
    assign fold = ^osc_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= PH_FIRST;
            first_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            if (phase_q == PH_FIRST) begin
                first_q <= fold;
                phase_q <= PH_SECOND;
            end else begin
                phase_q <= PH_FIRST;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        bit_o.vld = tick && (phase_q == PH_SECOND);
        bit_o.val = first_q ^ fold;
    end

endmodule

// File: rtl/ent_collector.sv
module ent_collector
    import ent_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ent_bit_t          bit_i,
    input  logic              clr_i,
    output logic [WORD_W-1:0] word_o,
    output logic              ready_o
);

    localparam int FRESH_W = $clog2(WORD_W + 1);
    localparam logic [FRESH_W-1:0] FULL = FRESH_W'(WORD_W);

    logic [WORD_W-1:0]  word_q;
    logic [FRESH_W-1:0] fresh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (bit_i.vld) begin
            word_q <= {word_q[WORD_W-2:0], bit_i.val};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh_q <= '0;
        end else if (clr_i) begin
            fresh_q <= bit_i.vld ? FRESH_W'(1) : '0;
        end else if (bit_i.vld && (fresh_q != FULL)) begin
            fresh_q <= fresh_q + 1'b1;
        end
    end

    assign word_o  = word_q;
    assign ready_o = (fresh_q == FULL);

endmodule

// File: rtl/osc_entropy_collector.sv
module osc_entropy_collector
    import ent_pkg::*;
#(
    parameter int NUM_OSC  = 32,
    parameter int INTERVAL = 4096,
    parameter int WORD_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OSC-1:0] osc_i,
    input  logic               rd_en,
    input  logic               rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    output logic [WORD_W-1:0]  word_o,
    output logic               ready_o
);

    ent_bit_t ent_bit;
    logic     data_rd;

    assign data_rd = rd_en && (rd_addr == ADDR_DATA);

    ent_sampler #(
        .NUM_OSC (NUM_OSC),
        .INTERVAL(INTERVAL)
    ) u_sampler (
        .clk  (clk),
        .rst  (rst),
        .osc_i(osc_i),
        .bit_o(ent_bit)
    );

    ent_collector #(
        .WORD_W(WORD_W)
    ) u_collector (
        .clk    (clk),
        .rst    (rst),
        .bit_i  (ent_bit),
        .clr_i  (data_rd),
        .word_o (word_o),
        .ready_o(ready_o)
    );

    always_comb begin
        if (rd_addr == ADDR_DATA) begin
            rd_data = word_o;
        end else begin
            rd_data = '0;
            rd_data[0] = ready_o;
        end
    end

endmodule

// File: rtl/osc_entropy_collector_chk.sv
module osc_entropy_collector_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              rd_addr,
    input logic [WORD_W-1:0] rd_data,
    input logic [WORD_W-1:0] word_o,
    input logic              ready_o,
    input logic              bvld,
    input logic              bval
);

    // R1: cleared state on the first cycle out of reset
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (word_o == '0) && !ready_o);

    // R2: the word moves only on entropy-bit edges
    assert_word_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !bvld |=> $stable(word_o));

    // R3: shift in at bit 0
    assert_shift_in_R3: assert property (@(posedge clk) disable iff (rst)
        bvld |=> (word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0])) && (word_o[0] == $past(bval)));

    // R6: data read on a quiet edge drops ready
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr && !bvld) |=> !ready_o);

    // R7: data read on a bit edge leaves ready low afterwards
    assert_read_on_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr && bvld) |=> !ready_o);

    // R8: status word has only bit 0 in use
    assert_status_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_addr |-> (rd_data[WORD_W-1:1] == '0));

    // R10: ready holds until a data read
    assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !(rd_en && rd_addr)) |=> ready_o);

endmodule

bind osc_entropy_collector osc_entropy_collector_chk #(
    .WORD_W(WORD_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .word_o (word_o),
    .ready_o(ready_o),
    .bvld   (ent_bit.vld),
    .bval   (ent_bit.val)
);

// File: tb/osc_entropy_collector_tb.sv
module osc_entropy_collector_tb;

    localparam int NOSC = 32;
    localparam int IV   = 4;
    localparam int W    = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NOSC-1:0] osc = '0;
    logic            rd_en = 1'b0;
    logic            rd_addr = 1'b0;
    logic [W-1:0]    rd_data;
    logic [W-1:0]    word;
    logic            ready;

    int n_chk = 0;
    int n_fail = 0;
    bit rand_on = 1'b0;
    bit done = 1'b0;

    osc_entropy_collector #(.NUM_OSC(NOSC), .INTERVAL(IV), .WORD_W(W)) u_dut (
        .clk(clk), .rst(rst), .osc_i(osc), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .word_o(word), .ready_o(ready)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: a queue of collected bits plus plain counters
    bit          mq[$];
    int          m_cyc = 0;
    int          m_samples = 0;
    bit          m_first = 1'b0;
    int          m_fresh = 0;
    int          m_bits = 0;
    bit          m_bit_next;
    logic [W-1:0] m_word;
    bit          m_ready;

    always_comb begin
        m_word = '0;
        foreach (mq[i]) m_word[mq.size() - 1 - i] = mq[i];
        m_ready = (m_fresh >= W);
        m_bit_next = ((m_cyc + 1) % IV == 0) && (m_samples % 2 == 1);
    end

    always @(posedge clk) begin
        bit nb;
        bit rd_clr;
        nb = 1'b0;
        rd_clr = rd_en && rd_addr;
        if (rst) begin
            mq.delete(); m_cyc = 0; m_samples = 0; m_first = 1'b0; m_fresh = 0;
        end else begin
            m_cyc++;
            if (m_cyc % IV == 0) begin
                if (m_samples % 2 == 0) m_first = ^osc;
                else begin
                    nb = 1'b1;
                    mq.push_back(m_first ^ (^osc));
                    if (mq.size() > W) void'(mq.pop_front());
                end
                m_samples++;
            end
            if (rd_clr) m_fresh = nb ? 1 : 0;
            else if (nb) m_fresh++;
            if (nb) m_bits++;
        end
        #1;
        chk(word == m_word, "R3 word vs model", word, m_word);
        chk(ready == m_ready, "R5 ready vs model", W'(ready), W'(m_ready));
        chk(rd_data == (rd_addr ? m_word : W'(m_ready)), "R8 rd_data vs model",
            rd_data, rd_addr ? m_word : W'(m_ready));
    end

    always @(negedge clk) if (rand_on) osc <= NOSC'($urandom);

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [W-1:0] snap;
        int b0;
        // R1
        repeat (3) @(negedge clk);
        chk(word == '0 && ready == 1'b0, "R1 in reset", {word[W-1:1], ready}, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(word == '0 && ready == 1'b0, "R1 after reset", {word[W-1:1], ready}, '0);

        // R2 / R3 directed: first sample parity 0, second parity 1
        rst = 1'b1; osc = '0; @(negedge clk); rst = 1'b0;
        repeat (IV) @(negedge clk);
        osc = 32'h0000_0007;
        repeat (IV - 1) @(negedge clk);
        chk(word == '0, "R2 no bit before second sample", word, '0);
        @(negedge clk);
        chk(word == W'(1), "R3 bit is xor of two folds", word, W'(1));

        // R5 / R10 / R4: free running, no reads
        rand_on = 1'b1;
        wait (m_bits == 40); @(negedge clk);
        chk(ready == 1'b1, "R10 ready held past saturation", W'(ready), W'(1));
        snap = word;
        b0 = m_bits;
        wait (m_bits == b0 + 3); @(negedge clk);
        chk(word != snap, "R4 shifting continues", word, ~snap);

        // R9: status reads
        rd_en = 1'b1; rd_addr = 1'b0;
        repeat (20) @(negedge clk);
        rd_en = 1'b0;
        chk(ready == 1'b1, "R9 status read keeps ready", W'(ready), W'(1));

        // R6: data read on a quiet edge
        while (m_bit_next) @(negedge clk);
        rd_en = 1'b1; rd_addr = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; rd_addr = 1'b0;
        chk(ready == 1'b0, "R6 data read clears ready", W'(ready), '0);
        b0 = m_bits;
        wait (m_bits == b0 + W - 1); @(negedge clk);
        chk(ready == 1'b0, "R6 not ready after W-1 bits", W'(ready), '0);
        wait (m_bits == b0 + W); @(negedge clk);
        chk(ready == 1'b1, "R5 ready after W bits", W'(ready), W'(1));

        // R7: data read on the same edge as a new bit
        while (!m_bit_next) @(negedge clk);
        rd_en = 1'b1; rd_addr = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; rd_addr = 1'b0;
        chk(ready == 1'b0, "R7 coincident read clears ready", W'(ready), '0);
        b0 = m_bits;
        wait (m_bits == b0 + W - 2); @(negedge clk);
        chk(ready == 1'b0, "R7 not ready after W-2 further bits", W'(ready), '0);
        wait (m_bits == b0 + W - 1); @(negedge clk);
        chk(ready == 1'b1, "R7 ready after W-1 further bits", W'(ready), W'(1));

        // R1: reset mid-run
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk(word == '0 && ready == 1'b0, "R1 mid-run reset", {word[W-1:1], ready}, '0);
        repeat (50) @(negedge clk);

        finish_run();
    end

endmodule